// File: doc/BRIEF.md
# Iterative Multiply-Divide Unit with Implicit Result Pair

This block performs integer multiplication and division on a pair of W-bit result registers, the high half (MDH) and the low half (MDL), that serve as implicit operands. A multiply takes two W-bit operands from its ports and leaves the 2W-bit product in the pair. A divide takes its dividend from the pair: either the low half alone (short form) or both halves joined as a 2W-bit value (long form). The divisor comes from a port. Both multiply and divide exist in signed (two's complement) and unsigned flavours.

The host loads or reads the pair through dedicated write strobes and read ports whenever the unit is idle. It then pulses `start` with an operation code. The unit computes one bit per clock with a radix-2 shift-add or restoring-subtract loop, runs one sign-correction cycle, and then writes the pair and raises `done` for a single cycle. A zero divisor and a quotient that does not fit in W bits are reported through two flags. In both of those cases the pair keeps its old contents.

Top module: `md_unit`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `hi_q` and `lo_q` are zero and `busy`, `done`, `div_zero` and `ovf` are low.
- R2: While the unit is idle and `start` is low, `hi_wr` and `lo_wr` load `hi_wdata` and `lo_wdata` into the high and low halves, visible the next cycle. Writes made while `busy` is high or in the cycle `start` is accepted are ignored, and the halves do not change while `busy` is high.
- R3: Opcode 3'd0 is a signed multiply: operands `opnd_a` and `opnd_b` are two's complement, the product's upper W bits go to the high half and its lower W bits to the low half.
- R4: Opcode 3'd1 is an unsigned multiply with the same placement of the product.
- R5: Opcodes 3'd2 (signed) and 3'd3 (unsigned) are short divides. The dividend is the low half alone, sign-extended for the signed form. The divisor is `opnd_b`. The quotient goes to the low half and the remainder to the high half.
- R6: Opcodes 3'd4 (signed) and 3'd5 (unsigned) are long divides of the 2W-bit value {high, low} by `opnd_b`, with the same result placement. Signed quotients truncate toward zero and signed remainders carry the sign of the dividend.
- R7: A divide whose `opnd_b` is zero raises `done` and `div_zero` in the cycle after `start`, never raises `busy`, leaves both halves unchanged and clears `ovf`.
- R8: A divide whose quotient lies outside the W-bit range of its form raises `ovf` with `done` and leaves both halves unchanged. The signed range is -2^(W-1) .. 2^(W-1)-1 and the unsigned range is 0 .. 2^W-1.
- R9: A multiply or a divide with a nonzero divisor holds `busy` high for exactly W+1 cycles after the `start` cycle. `done` is high for the one cycle after that, together with the new register values. A `start` while `busy` is high is ignored.
- R10: Opcodes 3'd6 and 3'd7 are reserved. They raise `done` in the next cycle, clear both flags and change nothing else.
- R11: `div_zero` and `ovf` change only in a cycle where `done` is high. Every completion rewrites both flags, and a multiply clears them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken when idle) |
| op | input | 3 | Operation code |
| opnd_a | input | W | Multiplicand (multiply only) |
| opnd_b | input | W | Multiplier or divisor |
| hi_wr | input | 1 | Load high half |
| hi_wdata | input | W | Data for high half |
| lo_wr | input | 1 | Load low half |
| lo_wdata | input | W | Data for low half |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| div_zero | output | 1 | Last divide had a zero divisor |
| ovf | output | 1 | Last divide quotient out of range |
| hi_q | output | W | High half of the result pair |
| lo_q | output | W | Low half of the result pair |

## Verification
The bench builds the unit with W=4. At that width every operand pair of both multiplies and every dividend and divisor combination of all four divides, including the full 256-value long dividend space, can be swept and checked against arithmetic done in the bench. This exhaustive coverage includes every overflow and zero-divisor case, the most-negative dividend divided by minus one, and the exact completion latency for each operation. Directed sequences then cover reserved opcodes, starts and host writes attempted while busy, and flags holding across idle cycles.

// File: rtl/md_pkg.sv
package md_pkg;

    typedef enum logic [2:0] {
        MD_MUL_S  = 3'd0,
        MD_MUL_U  = 3'd1,
        MD_DIV_S  = 3'd2,
        MD_DIV_U  = 3'd3,
        MD_DIVL_S = 3'd4,
        MD_DIVL_U = 3'd5,
        MD_RSV_6  = 3'd6,
        MD_RSV_7  = 3'd7
    } md_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ITER = 2'd1,
        ST_FIX  = 2'd2
    } md_state_e;

    typedef struct packed {
        logic valid;
        logic is_div;
        logic is_signed;
        logic is_long;
    } md_dec_t;

    function automatic md_dec_t md_decode(md_op_e code);
        md_dec_t d;
        d.valid     = (code != MD_RSV_6) && (code != MD_RSV_7);
        d.is_div    = (code == MD_DIV_S) || (code == MD_DIV_U) ||
                      (code == MD_DIVL_S) || (code == MD_DIVL_U);
        d.is_signed = (code == MD_MUL_S) || (code == MD_DIV_S) || (code == MD_DIVL_S);
        d.is_long   = (code == MD_DIVL_S) || (code == MD_DIVL_U);
        return d;
    endfunction

endpackage

// File: rtl/md_mul_step.sv
// One shift-add step: conditionally add the multiplicand to the upper half,
// then shift the joined accumulator right by one place.
module md_mul_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] acc_hi,
    input  logic [W-1:0] acc_lo,
    input  logic [W-1:0] mcand,
    output logic [W-1:0] nxt_hi,
    output logic [W-1:0] nxt_lo
);
    logic [W:0] sum;

    always_comb begin
        sum    = {1'b0, acc_hi} + (acc_lo[0] ? {1'b0, mcand} : '0);
        nxt_hi = sum[W:1];
        nxt_lo = {sum[0], acc_lo[W-1:1]};
    end
endmodule

// File: rtl/md_div_step.sv
// One restoring-division step: shift one dividend bit into the partial
// remainder, subtract the divisor when it fits, record the quotient bit.
module md_div_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] rem,
    input  logic [W-1:0] quo,
    input  logic [W-1:0] dvsr,
    output logic [W-1:0] nxt_rem,
    output logic [W-1:0] nxt_quo
);
    logic [W:0] shifted;
    logic [W:0] diff;
    logic       fits;

    always_comb begin
        shifted = {rem, quo[W-1]};
        diff    = shifted - {1'b0, dvsr};
        fits    = shifted >= {1'b0, dvsr};
        nxt_rem = fits ? diff[W-1:0] : shifted[W-1:0];
        nxt_quo = {quo[W-2:0], fits};
    end
endmodule

// File: rtl/md_fixup.sv
// Final cycle: restore signs on the magnitude result and judge whether a
// quotient fits in the W-bit range of its form.
module md_fixup #(
    parameter int W = 16
) (
    input  logic         is_div,
    input  logic         is_signed,
    input  logic         neg_res,
    input  logic         neg_rem,
    input  logic         pre_ovf,
    input  logic [W-1:0] acc_hi,
    input  logic [W-1:0] acc_lo,
    output logic [W-1:0] res_hi,
    output logic [W-1:0] res_lo,
    output logic         ovf
);
    localparam logic [W-1:0] HALF = {1'b1, {(W-1){1'b0}}};

    logic [2*W-1:0] prod;
    logic [2*W-1:0] prod_s;
    logic [W-1:0]   quo_s;
    logic [W-1:0]   rem_s;
    logic           range_bad;

    always_comb begin
        prod      = {acc_hi, acc_lo};
        prod_s    = neg_res ? -prod : prod;
        quo_s     = neg_res ? -acc_lo : acc_lo;
        rem_s     = neg_rem ? -acc_hi : acc_hi;
        range_bad = is_signed & (neg_res ? (acc_lo > HALF) : (acc_lo >= HALF));
        ovf       = is_div & (pre_ovf | range_bad);
        res_hi    = is_div ? rem_s : prod_s[2*W-1:W];
        res_lo    = is_div ? quo_s : prod_s[W-1:0];
    end
endmodule

// File: rtl/md_unit.sv
module md_unit
    import md_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [2:0]   op,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic         hi_wr,
    input  logic [W-1:0] hi_wdata,
    input  logic         lo_wr,
    input  logic [W-1:0] lo_wdata,
    output logic         busy,
    output logic         done,
    output logic         div_zero,
    output logic         ovf,
    output logic [W-1:0] hi_q,
    output logic [W-1:0] lo_q
);
    localparam int            CW   = (W > 2) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    md_state_e      state_q;
    logic [CW-1:0]  cnt_q;
    logic [W-1:0]   acc_hi_q, acc_lo_q, opnd_q;
    logic           div_q, sgn_q, neg_res_q, neg_rem_q, pre_ovf_q;
    logic [W-1:0]   md_hi_q, md_lo_q;
    logic           done_q, dz_q, ovf_q;

    // decode and operand preparation for the start cycle
    md_dec_t        dec;
    logic           accept, launch;
    logic           a_neg, b_neg, dvd_neg;
    logic [W-1:0]   a_mag, b_mag;
    logic [2*W-1:0] dvd_raw, dvd_mag;
    logic [W-1:0]   ld_hi, ld_lo;
    logic           ld_neg_res, ld_neg_rem, ld_pre_ovf;

    always_comb begin
        dec     = md_decode(md_op_e'(op));
        accept  = (state_q == ST_IDLE) && start;
        launch  = accept && dec.valid && !(dec.is_div && (opnd_b == '0));
        a_neg   = dec.is_signed & opnd_a[W-1];
        b_neg   = dec.is_signed & opnd_b[W-1];
        a_mag   = a_neg ? -opnd_a : opnd_a;
        b_mag   = b_neg ? -opnd_b : opnd_b;
        if (dec.is_long)
            dvd_raw = {md_hi_q, md_lo_q};
        else if (dec.is_signed)
            dvd_raw = {{W{md_lo_q[W-1]}}, md_lo_q};
        else
            dvd_raw = {{W{1'b0}}, md_lo_q};
        dvd_neg = dec.is_signed & dvd_raw[2*W-1];
        dvd_mag = dvd_neg ? -dvd_raw : dvd_raw;
        if (dec.is_div) begin
            ld_hi      = dvd_mag[2*W-1:W];
            ld_lo      = dvd_mag[W-1:0];
            ld_neg_res = dvd_neg ^ b_neg;
            ld_neg_rem = dvd_neg;
            ld_pre_ovf = dvd_mag[2*W-1:W] >= b_mag;
        end else begin
            ld_hi      = '0;
            ld_lo      = a_mag;
            ld_neg_res = a_neg ^ b_neg;
            ld_neg_rem = 1'b0;
            ld_pre_ovf = 1'b0;
        end
    end

    // iteration datapaths
    logic [W-1:0] mul_hi, mul_lo, div_hi, div_lo;

    md_mul_step #(.W(W)) u_mul (
        .acc_hi (acc_hi_q),
        .acc_lo (acc_lo_q),
        .mcand  (opnd_q),
        .nxt_hi (mul_hi),
        .nxt_lo (mul_lo)
    );

    md_div_step #(.W(W)) u_div (
        .rem     (acc_hi_q),
        .quo     (acc_lo_q),
        .dvsr    (opnd_q),
        .nxt_rem (div_hi),
        .nxt_quo (div_lo)
    );

    logic [W-1:0] fix_hi, fix_lo;
    logic         fix_ovf;

    md_fixup #(.W(W)) u_fix (
        .is_div    (div_q),
        .is_signed (sgn_q),
        .neg_res   (neg_res_q),
        .neg_rem   (neg_rem_q),
        .pre_ovf   (pre_ovf_q),
        .acc_hi    (acc_hi_q),
        .acc_lo    (acc_lo_q),
        .res_hi    (fix_hi),
        .res_lo    (fix_lo),
        .ovf       (fix_ovf)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            cnt_q     <= '0;
            acc_hi_q  <= '0;
            acc_lo_q  <= '0;
            opnd_q    <= '0;
            div_q     <= 1'b0;
            sgn_q     <= 1'b0;
            neg_res_q <= 1'b0;
            neg_rem_q <= 1'b0;
            pre_ovf_q <= 1'b0;
            md_hi_q   <= '0;
            md_lo_q   <= '0;
            done_q    <= 1'b0;
            dz_q      <= 1'b0;
            ovf_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (launch) begin
                        state_q   <= ST_ITER;
                        cnt_q     <= '0;
                        acc_hi_q  <= ld_hi;
                        acc_lo_q  <= ld_lo;
                        opnd_q    <= b_mag;
                        div_q     <= dec.is_div;
                        sgn_q     <= dec.is_signed;
                        neg_res_q <= ld_neg_res;
                        neg_rem_q <= ld_neg_rem;
                        pre_ovf_q <= ld_pre_ovf;
                    end else if (accept) begin
                        // zero divisor or reserved code: finish at once
                        done_q <= 1'b1;
                        dz_q   <= dec.valid;
                        ovf_q  <= 1'b0;
                    end else begin
                        if (hi_wr) md_hi_q <= hi_wdata;
                        if (lo_wr) md_lo_q <= lo_wdata;
                    end
                end
                ST_ITER: begin
                    acc_hi_q <= div_q ? div_hi : mul_hi;
                    acc_lo_q <= div_q ? div_lo : mul_lo;
                    cnt_q    <= cnt_q + 1'b1;
                    if (cnt_q == LAST) state_q <= ST_FIX;
                end
                ST_FIX: begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                    dz_q    <= 1'b0;
                    ovf_q   <= fix_ovf;
                    if (!fix_ovf) begin
                        md_hi_q <= fix_hi;
                        md_lo_q <= fix_lo;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy     = (state_q != ST_IDLE);
    assign done     = done_q;
    assign div_zero = dz_q;
    assign ovf      = ovf_q;
    assign hi_q     = md_hi_q;
    assign lo_q     = md_lo_q;

endmodule

// File: rtl/md_unit_chk.sv
module md_unit_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic [2:0]   op,
    input logic [W-1:0] opnd_b,
    input logic         hi_wr,
    input logic [W-1:0] hi_wdata,
    input logic         lo_wr,
    input logic [W-1:0] lo_wdata,
    input logic         busy,
    input logic         done,
    input logic         div_zero,
    input logic         ovf,
    input logic [W-1:0] hi_q,
    input logic [W-1:0] lo_q
);
    logic is_div_op, is_rsv_op;
    assign is_div_op = (op >= 3'd2) && (op <= 3'd5);
    assign is_rsv_op = (op[2:1] == 2'b11);

    // R2: idle host writes land in the next cycle
    p_host_wr_r2: assert property (@(posedge clk) disable iff (rst)
        (hi_wr && lo_wr && !busy && !start) |=> (hi_q == $past(hi_wdata)) && (lo_q == $past(lo_wdata)));

    // R2: the pair is frozen during an operation
    p_md_hold_busy_r2: assert property (@(posedge clk) disable iff (rst)
        busy |-> ($stable(hi_q) && $stable(lo_q)));

    // R7: zero divisor completes at once without touching the pair
    p_zero_div_r7: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && is_div_op && (opnd_b == '0)) |=>
            (done && div_zero && !ovf && !busy && $stable(hi_q) && $stable(lo_q)));

    // R7: the two flags never stand together
    p_flag_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(div_zero && ovf));

    // R8: an overflowing divide keeps the old pair
    p_ovf_keep_r8: assert property (@(posedge clk) disable iff (rst)
        (done && ovf) |-> ($stable(hi_q) && $stable(lo_q)));

    // R9: a real operation goes busy on the next cycle
    p_busy_start_r9: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !is_rsv_op && !(is_div_op && (opnd_b == '0))) |=> busy);

    // R9: completion is reported only when idle
    p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R10: reserved codes finish at once with clear flags
    p_rsv_r10: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && is_rsv_op) |=> (done && !div_zero && !ovf));

    // R11: flags move only with a completion
    p_flag_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(div_zero) && $stable(ovf)));

endmodule

bind md_unit md_unit_chk #(.W(W)) u_md_unit_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .op       (op),
    .opnd_b   (opnd_b),
    .hi_wr    (hi_wr),
    .hi_wdata (hi_wdata),
    .lo_wr    (lo_wr),
    .lo_wdata (lo_wdata),
    .busy     (busy),
    .done     (done),
    .div_zero (div_zero),
    .ovf      (ovf),
    .hi_q     (hi_q),
    .lo_q     (lo_q)
);

// File: tb/test_md_unit.sv
module test_md_unit;
    localparam int  W  = 4;
    localparam longint M  = (64'sd1 <<< W) - 1;
    localparam longint M2 = (64'sd1 <<< (2*W)) - 1;
    localparam int  WD = 190000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [2:0]   op = '0;
    logic [W-1:0] opnd_a = '0, opnd_b = '0;
    logic         hi_wr = 1'b0, lo_wr = 1'b0;
    logic [W-1:0] hi_wdata = '0, lo_wdata = '0;
    logic         busy, done, div_zero, ovf;
    logic [W-1:0] hi_q, lo_q;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;   // 50 MHz

    md_unit #(.W(W)) i_md_unit (
        .clk(clk), .rst(rst), .start(start), .op(op),
        .opnd_a(opnd_a), .opnd_b(opnd_b),
        .hi_wr(hi_wr), .hi_wdata(hi_wdata), .lo_wr(lo_wr), .lo_wdata(lo_wdata),
        .busy(busy), .done(done), .div_zero(div_zero), .ovf(ovf),
        .hi_q(hi_q), .lo_q(lo_q)
    );

    task automatic chk(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic longint sx(longint v, int bits);
        longint m = (64'sd1 <<< bits) - 1;
        v = v & m;
        if (v[bits-1]) return v - (64'sd1 <<< bits);
        return v;
    endfunction

    function automatic longint pack_out(logic dz, logic ov, logic [W-1:0] h, logic [W-1:0] l);
        return (longint'(dz) <<< (2*W+1)) | (longint'(ov) <<< (2*W)) |
               (longint'(h) <<< W) | longint'(l);
    endfunction

    function automatic string req_of(int code);
        case (code)
            0: return "R3";
            1: return "R4";
            2, 3: return "R5";
            4, 5: return "R6";
            default: return "R10";
        endcase
    endfunction

    // load the pair, issue one operation, compare the outcome and its latency
    task automatic run_op(int code, longint a, longint b, longint mh, longint ml);
        longint eh = mh, el = ml, p, dvd, dvs, q, r;
        logic   ez = 1'b0, eo = 1'b0;
        int     elat, cyc;
        string  rq = req_of(code);
        elat = W + 2;
        case (code)
            0, 1: begin
                p  = (code == 0) ? sx(a, W) * sx(b, W) : (a & M) * (b & M);
                p  = p & M2;
                eh = p >>> W;
                el = p & M;
            end
            2, 3, 4, 5: begin
                dvd = (code >= 4) ? (((mh & M) <<< W) | (ml & M)) : (ml & M);
                if (code == 2) dvd = sx(dvd, W);
                if (code == 4) dvd = sx(dvd, 2*W);
                dvs = (code == 2 || code == 4) ? sx(b, W) : (b & M);
                if (dvs == 0) begin
                    ez   = 1'b1;
                    elat = 1;
                    rq   = "R7";
                end else begin
                    q = dvd / dvs;
                    r = dvd % dvs;
                    if (code == 2 || code == 4)
                        eo = (q > (64'sd1 <<< (W-1)) - 1) || (q < -(64'sd1 <<< (W-1)));
                    else
                        eo = (q > M);
                    if (eo) rq = "R8";
                    else begin
                        eh = r & M;
                        el = q & M;
                    end
                end
            end
            default: elat = 1;
        endcase
        @(negedge clk);
        hi_wr = 1'b1; hi_wdata = W'(mh);
        lo_wr = 1'b1; lo_wdata = W'(ml);
        @(negedge clk);
        hi_wr = 1'b0; lo_wr = 1'b0;
        start = 1'b1; op = 3'(code); opnd_a = W'(a); opnd_b = W'(b);
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 64) begin
            @(negedge clk);
            cyc++;
        end
        chk(rq, $sformatf("op%0d a=%0d b=%0d md=%0d:%0d result", code, a, b, mh, ml),
            pack_out(div_zero, ovf, hi_q, lo_q), pack_out(ez, eo, W'(eh), W'(el)));
        chk("R9", $sformatf("op%0d latency", code), cyc, elat);
    endtask

    initial begin
        repeat (WD) @(posedge clk);
        n_fail++;
        $display("FAIL R9 watchdog: actual hung expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int cyc;
        repeat (3) @(negedge clk);
        // R1: state during and right after reset
        chk("R1", "reset outputs", pack_out(div_zero, ovf, hi_q, lo_q) | (longint'(busy) <<< 20) | (longint'(done) <<< 21), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "first cycle after reset", pack_out(div_zero, ovf, hi_q, lo_q) | (longint'(busy) <<< 20) | (longint'(done) <<< 21), 0);

        // R2: idle host writes
        hi_wr = 1'b1; hi_wdata = 4'hA; lo_wr = 1'b1; lo_wdata = 4'h5;
        @(negedge clk);
        hi_wr = 1'b0; lo_wr = 1'b0;
        chk("R2", "host write high", hi_q, 10);
        chk("R2", "host write low", lo_q, 5);

        // R3, R4: every operand pair
        for (int c = 0; c < 2; c++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++)
                    run_op(c, a, b, (a ^ 5), (b ^ 10));

        // R5: every short dividend and divisor (zero divisor included, R7)
        for (int c = 2; c < 4; c++)
            for (int l = 0; l < 16; l++)
                for (int b = 0; b < 16; b++)
                    run_op(c, 0, b, (~l) & 15, l);

        // R6, R8: every long dividend and divisor
        for (int c = 4; c < 6; c++)
            for (int h = 0; h < 16; h++)
                for (int l = 0; l < 16; l++)
                    for (int b = 0; b < 16; b++)
                        run_op(c, 0, b, h, l);

        // R10: reserved codes
        run_op(6, 3, 0, 7, 9);
        run_op(7, 3, 5, 12, 1);

        // R11: flag from a zero divide holds through idle cycles
        run_op(3, 0, 0, 2, 6);
        repeat (5) @(negedge clk);
        chk("R11", "div_zero held while idle", div_zero, 1);
        run_op(1, 2, 3, 0, 0);
        chk("R11", "multiply clears div_zero", div_zero, 0);

        // R9 and R2: start and host write while busy are ignored
        @(negedge clk);
        start = 1'b1; op = 3'd1; opnd_a = 4'd3; opnd_b = 4'd5;
        @(negedge clk);
        start = 1'b1; op = 3'd0; opnd_a = 4'd7; opnd_b = 4'd7;
        hi_wr = 1'b1; hi_wdata = 4'hF; lo_wr = 1'b1; lo_wdata = 4'hF;
        @(negedge clk);
        start = 1'b0; hi_wr = 1'b0; lo_wr = 1'b0;
        cyc = 2;
        while (!done && cyc < 64) begin
            @(negedge clk);
            cyc++;
        end
        chk("R9", "latency with start while busy", cyc, W + 2);
        chk("R2", "write during busy ignored, high", hi_q, 0);
        chk("R9", "second start ignored, low", lo_q, 15);
        repeat (3) @(negedge clk);
        chk("R9", "unit idle after ignored start", busy, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule